// File: doc/BRIEF.md
# Single-Tap Echo Canceller with Reciprocal Normalisation

This block is a feed-forward time-domain equalizer for a line-of-sight channel that has two paths: a direct path and one weaker reflection. Each accepted complex sample has the reflection removed. The reflection is rebuilt from the sample accepted `d` positions earlier, scaled by a precomputed complex ratio (reflection gain over main gain). The result is then normalised by the main-path gain. No complex divider is used. The difference is multiplied by the conjugate of the main gain and then by a real reciprocal of the main-path power. That reciprocal comes from a computed lookup with a 15-bit input and a 13-bit output.

A channel estimator that sits upstream supplies the coefficients through a one-cycle load strobe. The load strobe also restarts the delay history, and the coefficients then stay fixed for the whole payload. The datapath has no feedback, so it is split into three register stages. The equalized stream goes on to an FFT or a demapper.

Top module: `tap_canceller`

## Requirements
- R1: Every sample taken with `valid_i`=1 and `load_i`=0 produces exactly one `valid_o` pulse three clock edges later. `valid_o` is never high otherwise.
- R2: The cancelled value is `e = r[n] - rnd(a * r[n-d])`. The complex ratio `a` is signed with 8 fraction bits. `rnd` adds half an LSB and shifts arithmetically, so ties round toward plus infinity.
- R3: The delayed term is zero while fewer than `d` samples have been accepted since the last load or reset. `d`=0 disables cancellation. A `d` above 128 is treated as 128.
- R4: The reciprocal is `min(8191, floor(2^20 / p))`, where `p` is `power_i`. `p`=0 gives 8191.
- R5: Output real part is `rnd16((er*hr + ei*hi) * recip)`. Output imaginary part is `rnd16((ei*hr - er*hi) * recip)`. Here `h` is the main gain and `rnd16` rounds half up before an arithmetic shift right by 16.
- R6: Each output component saturates to the range -16384 to 16383.
- R7: `load_i` latches ratio, main gain, power and delay, and restarts the history. A sample presented in the load cycle is dropped, gives no output and leaves the outputs unchanged.
- R8: After reset, `valid_o` is 0 and both outputs are 0. Before any load, every coefficient is zero, so accepted samples produce zero outputs.
- R9: While `valid_o` is low, both outputs hold the last equalized value.
- R10: The delay counts accepted samples, not clock cycles. Idle cycles between samples do not shift the alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Coefficient load and history restart |
| ratio_re_i | input | 10 | Real part of the reflection/main ratio, 8 fraction bits |
| ratio_im_i | input | 10 | Imaginary part of the ratio |
| main_re_i | input | 9 | Real part of the main-path gain |
| main_im_i | input | 9 | Imaginary part of the main-path gain |
| power_i | input | 15 | Main-path power, unsigned |
| delay_i | input | 8 | Reflection delay in samples |
| valid_i | input | 1 | Input sample strobe |
| rx_re_i | input | 9 | Received sample, real part |
| rx_im_i | input | 9 | Received sample, imaginary part |
| valid_o | output | 1 | Output sample strobe |
| eq_re_o | output | 15 | Equalized real part |
| eq_im_o | output | 15 | Equalized imaginary part |

## Verification
The assertions check on every cycle the properties that hold regardless of the data:
- the three-edge latency of the strobe, and the dropping of a sample that arrives with a load;
- the history counter clearing on load and staying bounded;
- the reciprocal never being zero and staying constant between loads;
- the outputs holding while no result is produced.

The arithmetic itself can only be shown by the bench's scenarios, which compare every output against an independent model. This covers:
- alignment of the reflection across idle gaps and at the 128-sample limit;
- rounding of ties;
- the cross terms of the conjugate product;
- the reciprocal clamp;
- saturation in both directions.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int unsigned WIDE = 48;
  typedef logic signed [WIDE-1:0] wide_t;

  // round half toward +inf, then arithmetic shift
  function automatic wide_t round_shr(wide_t x, int unsigned sh);
    wide_t half;
    half = (sh == 0) ? '0 : (wide_t'(1) <<< (sh - 1));
    return (x + half) >>> sh;
  endfunction

  function automatic wide_t clip(wide_t x, int unsigned w);
    wide_t hi, lo;
    hi = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
    lo = -(wide_t'(1) <<< (w - 1));
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction
endpackage

// File: rtl/tc_delay_line.sv
module tc_delay_line #(
  parameter int unsigned DW      = 9,
  parameter int unsigned MAX_DLY = 128,
  parameter int unsigned DLYW    = $clog2(MAX_DLY + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 shift_i,
  input  logic signed [DW-1:0] din_re_i,
  input  logic signed [DW-1:0] din_im_i,
  input  logic [DLYW-1:0]      dly_i,
  output logic signed [DW-1:0] tap_re_o,
  output logic signed [DW-1:0] tap_im_o
);
  localparam int unsigned IW = $clog2(MAX_DLY);

  logic [2*DW-1:0] line_q [MAX_DLY];
  logic [DLYW-1:0] fill_q;
  logic [IW-1:0]   idx;
  logic            primed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(MAX_DLY); i++) line_q[i] <= '0;
    end else if (shift_i) begin
      line_q[0] <= {din_re_i, din_im_i};
      for (int i = 1; i < int'(MAX_DLY); i++) line_q[i] <= line_q[i-1];
    end
  end

  // accepted samples since restart, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    fill_q <= '0;
    else if (clr_i)                                 fill_q <= '0;
    else if (shift_i && fill_q != DLYW'(MAX_DLY))   fill_q <= fill_q + 1'b1;
  end

  assign idx    = IW'(dly_i - 1'b1);
  assign primed = (dly_i != '0) && (fill_q >= dly_i);
  assign {tap_re_o, tap_im_o} = primed ? line_q[idx] : '0;

  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= DLYW'(MAX_DLY)); // R3
  AST_FILL_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> fill_q == '0); // R7
endmodule

// File: rtl/tc_recip_lut.sv
module tc_recip_lut #(
  parameter int unsigned PW          = 15,
  parameter int unsigned LW          = 13,
  parameter int unsigned RECIP_SHIFT = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [PW-1:0] power_i,
  output logic [LW-1:0] recip_o
);
  localparam int unsigned    NUMW = RECIP_SHIFT + 1;
  localparam logic [NUMW-1:0] NUM  = NUMW'(1) << RECIP_SHIFT;
  localparam logic [NUMW-1:0] LMAX = NUMW'((1 << LW) - 1);

  logic [NUMW-1:0] quo;
  logic [LW-1:0]   entry;

  always_comb begin
    quo   = (power_i == '0) ? LMAX : NUM / NUMW'(power_i);
    entry = (quo > LMAX) ? LW'(LMAX) : LW'(quo);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     recip_o <= LW'(LMAX);
    else if (load_i) recip_o <= entry;
  end

  AST_RECIP_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recip_o != '0); // R4
  AST_RECIP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(recip_o)); // R7
endmodule

// File: rtl/tc_conj_scale.sv
module tc_conj_scale
  import tc_pkg::*;
#(
  parameter int unsigned EW        = 13,
  parameter int unsigned GW        = 9,
  parameter int unsigned LW        = 13,
  parameter int unsigned OW        = 15,
  parameter int unsigned OUT_SHIFT = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic signed [EW-1:0] err_re_i,
  input  logic signed [EW-1:0] err_im_i,
  input  logic signed [GW-1:0] main_re_i,
  input  logic signed [GW-1:0] main_im_i,
  input  logic [LW-1:0]        recip_i,
  output logic                 vld_o,
  output logic signed [OW-1:0] y_re_o,
  output logic signed [OW-1:0] y_im_o
);
  localparam int unsigned MW = EW + GW + 1;

  logic signed [MW-1:0] m_re_q, m_im_q;
  logic                 v2_q;
  wide_t                er, ei, hr, hi, rc;

  assign er = wide_t'(err_re_i);
  assign ei = wide_t'(err_im_i);
  assign hr = wide_t'(main_re_i);
  assign hi = wide_t'(main_im_i);
  assign rc = wide_t'({1'b0, recip_i});

  // stage 2: multiply by conj(h0)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2_q   <= 1'b0;
      m_re_q <= '0;
      m_im_q <= '0;
    end else begin
      v2_q <= vld_i;
      if (vld_i) begin
        m_re_q <= MW'(er * hr + ei * hi);
        m_im_q <= MW'(ei * hr - er * hi);
      end
    end
  end

  // stage 3: real reciprocal, round, saturate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      y_re_o <= '0;
      y_im_o <= '0;
    end else begin
      vld_o <= v2_q;
      if (v2_q) begin
        y_re_o <= OW'(clip(round_shr(wide_t'(m_re_q) * rc, OUT_SHIFT), OW));
        y_im_o <= OW'(clip(round_shr(wide_t'(m_im_q) * rc, OUT_SHIFT), OW));
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v2_q |=> ($stable(y_re_o) && $stable(y_im_o))); // R9
endmodule

// File: rtl/tap_canceller.sv
module tap_canceller
  import tc_pkg::*;
#(
  parameter int unsigned DW          = 9,
  parameter int unsigned AW          = 10,
  parameter int unsigned AF          = 8,
  parameter int unsigned GW          = 9,
  parameter int unsigned PW          = 15,
  parameter int unsigned LW          = 13,
  parameter int unsigned OW          = 15,
  parameter int unsigned MAX_DLY     = 128,
  parameter int unsigned RECIP_SHIFT = 20,
  parameter int unsigned OUT_SHIFT   = 16,
  parameter int unsigned DLYW        = $clog2(MAX_DLY + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic signed [AW-1:0] ratio_re_i,
  input  logic signed [AW-1:0] ratio_im_i,
  input  logic signed [GW-1:0] main_re_i,
  input  logic signed [GW-1:0] main_im_i,
  input  logic [PW-1:0]        power_i,
  input  logic [DLYW-1:0]      delay_i,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] rx_re_i,
  input  logic signed [DW-1:0] rx_im_i,
  output logic                 valid_o,
  output logic signed [OW-1:0] eq_re_o,
  output logic signed [OW-1:0] eq_im_o
);
  localparam int unsigned EW = DW + AW - AF + 2;

  logic signed [AW-1:0] a_re_q, a_im_q;
  logic signed [GW-1:0] h_re_q, h_im_q;
  logic [DLYW-1:0]      d_q;
  logic [LW-1:0]        recip;
  logic                 acc;
  logic signed [DW-1:0] tap_re, tap_im;
  logic signed [EW-1:0] e_re_q, e_im_q;
  logic                 v1_q;
  wide_t                ar, ai, dr, di;

  assign acc = valid_i && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_re_q <= '0;
      a_im_q <= '0;
      h_re_q <= '0;
      h_im_q <= '0;
      d_q    <= '0;
    end else if (load_i) begin
      a_re_q <= ratio_re_i;
      a_im_q <= ratio_im_i;
      h_re_q <= main_re_i;
      h_im_q <= main_im_i;
      d_q    <= (delay_i > DLYW'(MAX_DLY)) ? DLYW'(MAX_DLY) : delay_i;
    end
  end

  tc_recip_lut #(.PW(PW), .LW(LW), .RECIP_SHIFT(RECIP_SHIFT)) i_recip (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .power_i (power_i),
    .recip_o (recip)
  );

  tc_delay_line #(.DW(DW), .MAX_DLY(MAX_DLY), .DLYW(DLYW)) i_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (load_i),
    .shift_i  (acc),
    .din_re_i (rx_re_i),
    .din_im_i (rx_im_i),
    .dly_i    (d_q),
    .tap_re_o (tap_re),
    .tap_im_o (tap_im)
  );

  assign ar = wide_t'(a_re_q);
  assign ai = wide_t'(a_im_q);
  assign dr = wide_t'(tap_re);
  assign di = wide_t'(tap_im);

  // stage 1: subtract the rebuilt reflection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      e_re_q <= '0;
      e_im_q <= '0;
    end else begin
      v1_q <= acc;
      if (acc) begin
        e_re_q <= EW'(wide_t'(rx_re_i) - round_shr(ar * dr - ai * di, AF));
        e_im_q <= EW'(wide_t'(rx_im_i) - round_shr(ar * di + ai * dr, AF));
      end
    end
  end

  tc_conj_scale #(.EW(EW), .GW(GW), .LW(LW), .OW(OW), .OUT_SHIFT(OUT_SHIFT)) i_scale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (v1_q),
    .err_re_i  (e_re_q),
    .err_im_i  (e_im_q),
    .main_re_i (h_re_q),
    .main_im_i (h_im_q),
    .recip_i   (recip),
    .vld_o     (valid_o),
    .y_re_o    (eq_re_o),
    .y_im_o    (eq_im_o)
  );

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> ##2 valid_o); // R1
  AST_LOAD_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ##2 !valid_o); // R7
endmodule

// File: tb/test_tap_canceller.sv
module test_tap_canceller;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0, valid_i = 1'b0;
  logic signed [9:0]  ratio_re = '0, ratio_im = '0;
  logic signed [8:0]  main_re = '0, main_im = '0;
  logic [14:0]        power = '0;
  logic [7:0]         delay = '0;
  logic signed [8:0]  rx_re = '0, rx_im = '0;
  logic               valid_o;
  logic signed [14:0] eq_re_o, eq_im_o;

  always #10 clk = ~clk;

  tap_canceller i_tap_canceller (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load_i),
    .ratio_re_i(ratio_re), .ratio_im_i(ratio_im),
    .main_re_i(main_re), .main_im_i(main_im),
    .power_i(power), .delay_i(delay),
    .valid_i(valid_i), .rx_re_i(rx_re), .rx_im_i(rx_im),
    .valid_o(valid_o), .eq_re_o(eq_re_o), .eq_im_o(eq_im_o)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;
  // model state
  int m_ar = 0, m_ai = 0, m_hr = 0, m_hi = 0, m_rc = 8191, m_d = 0, m_cnt = 0;
  int hist_re [256], hist_im [256];
  int q_re[$], q_im[$], q_cyc[$];
  string q_tag[$];
  int last_re = 0, last_im = 0;

  localparam int NVEC = 16;
  localparam int VEC_RE  [NVEC] = '{ 100, -50,  37, 255, -256,  0,  12,  -7, 90, -90, 200,  1, -1,  64, -128, 33};
  localparam int VEC_IM  [NVEC] = '{ -20,  80, -99,  10,   44, -1, 255, -256, 3,  -3,   0, 77, -77, 5,   19, -64};
  localparam int VEC_GAP [NVEC] = '{   0,   2,   0,   1,    0,  3,   0,    0, 5,   0,   1,  0,  2,  0,    0,  1};

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint rs(longint x, int s);
    return (x + (64'sd1 <<< (s - 1))) >>> s;
  endfunction
  function automatic longint sat(longint x);
    if (x > 16383) return 16383;
    if (x < -16384) return -16384;
    return x;
  endfunction

  task automatic chk(int got, int exp, string tag);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o) begin
        if (q_re.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R1: got unexpected valid_o expected none");
        end else begin
          chk(cyc, q_cyc.pop_front(), "R1 latency");
          chk(int'(eq_re_o), q_re.pop_front(), q_tag[0]);
          chk(int'(eq_im_o), q_im.pop_front(), q_tag[0]);
          void'(q_tag.pop_front());
        end
        last_re = int'(eq_re_o);
        last_im = int'(eq_im_o);
      end else if (int'(eq_re_o) != last_re || int'(eq_im_o) != last_im) begin
        chk(int'(eq_re_o), last_re, "R9 hold");
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int rr, int ri, string tag);
    int dr, di;
    longint er, ei, mr, mi;
    dr = (m_d != 0 && m_cnt >= m_d) ? hist_re[m_cnt - m_d] : 0;
    di = (m_d != 0 && m_cnt >= m_d) ? hist_im[m_cnt - m_d] : 0;
    er = rr - rs(longint'(m_ar) * dr - longint'(m_ai) * di, 8);
    ei = ri - rs(longint'(m_ar) * di + longint'(m_ai) * dr, 8);
    mr = er * m_hr + ei * m_hi;
    mi = ei * m_hr - er * m_hi;
    q_re.push_back(int'(sat(rs(mr * m_rc, 16))));
    q_im.push_back(int'(sat(rs(mi * m_rc, 16))));
    q_cyc.push_back(cyc + 3);
    q_tag.push_back(tag);
    hist_re[m_cnt] = rr;
    hist_im[m_cnt] = ri;
    m_cnt++;
    valid_i = 1'b1;
    rx_re = 9'(rr);
    rx_im = 9'(ri);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic load(int ar, int ai, int hr, int hi, int p, int d, bit with_valid);
    idle(4);
    load_i = 1'b1;
    valid_i = with_valid;
    rx_re = 9'sd77;
    rx_im = -9'sd5;
    ratio_re = 10'(ar); ratio_im = 10'(ai);
    main_re = 9'(hr); main_im = 9'(hi);
    power = 15'(p); delay = 8'(d);
    m_ar = ar; m_ai = ai; m_hr = hr; m_hi = hi;
    m_rc = (p == 0) ? 8191 : ((1048576 / p) > 8191 ? 8191 : 1048576 / p);
    m_d = (d > 128) ? 128 : d;
    m_cnt = 0;
    @(negedge clk);
    load_i = 1'b0;
    valid_i = 1'b0;
  endtask

  initial begin
    int pre_re;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(valid_o), 0, "R8 reset valid");
    chk(int'(eq_re_o), 0, "R8 reset re");
    chk(int'(eq_im_o), 0, "R8 reset im");
    send(50, 50, "R8 unloaded");
    idle(4);

    // table walk, idle gaps between samples
    load(64, -32, 16, 0, 256, 3, 1'b0);
    for (int i = 0; i < NVEC; i++) begin
      send(VEC_RE[i], VEC_IM[i], "R2/R10 table A");
      idle(VEC_GAP[i]);
    end
    load(-100, 40, 12, 5, 169, 5, 1'b0);
    for (int i = 0; i < NVEC; i++) begin
      send(VEC_RE[i], VEC_IM[i], "R5 table B");
      idle(VEC_GAP[NVEC - 1 - i]);
    end

    // reciprocal and normalisation
    load(0, 0, 16, 0, 256, 0, 1'b0);
    send(100, -37, "R5 unity");
    idle(4);
    chk(int'(eq_re_o), 100, "R5 unity re");
    chk(int'(eq_im_o), -37, "R5 unity im");
    load(0, 0, 16, 0, 0, 0, 1'b0);
    send(100, 0, "R4 zero power");
    idle(4);
    chk(int'(eq_re_o), 200, "R4 zero power");
    load(0, 0, 16, 0, 600, 0, 1'b0);
    send(100, 0, "R4 p600");
    idle(4);
    chk(int'(eq_re_o), 43, "R4 p600");

    // rounding ties
    load(128, 0, 16, 0, 256, 1, 1'b0);
    send(1, 0, "R2 round");  idle(3); chk(int'(eq_re_o), 1, "R3 unprimed");
    send(10, 0, "R2 round"); idle(3); chk(int'(eq_re_o), 9, "R2 half up pos");
    send(-1, 0, "R2 round"); idle(3); chk(int'(eq_re_o), -6, "R2 round");
    send(0, 0, "R2 round");  idle(3); chk(int'(eq_re_o), 0, "R2 half up neg");

    // saturation
    load(-512, 0, 255, 0, 1, 1, 1'b0);
    send(255, 0, "R6 sat");  idle(3); chk(int'(eq_re_o), 8127, "R6 below limit");
    send(255, 0, "R6 sat");  idle(3); chk(int'(eq_re_o), 16383, "R6 pos sat");
    send(-256, 0, "R6 sat"); idle(3);
    send(-256, 0, "R6 sat"); idle(3); chk(int'(eq_re_o), -16384, "R6 neg sat");

    // d = 0 and maximum delay
    load(256, 0, 16, 0, 256, 0, 1'b0);
    send(40, -3, "R3 d0"); send(41, 8, "R3 d0"); idle(4);
    chk(int'(eq_re_o), 41, "R3 d0 no cancel");
    load(256, 0, 16, 0, 256, 128, 1'b0);
    for (int i = 0; i < 140; i++) send(i % 50 - 20, 3, "R3 d128");
    idle(4);
    chk(int'(eq_re_o), 28, "R3 d128 re");
    chk(int'(eq_im_o), 0, "R3 d128 im");
    load(256, 0, 16, 0, 256, 200, 1'b0);
    for (int i = 0; i < 130; i++) send(i - 60, 1, "R3 clamp");
    idle(4);
    chk(int'(eq_re_o), 128, "R3 clamp");

    // sample in load cycle dropped
    pre_re = int'(eq_re_o);
    load(0, 0, 16, 0, 256, 0, 1'b1);
    idle(5);
    chk(int'(eq_re_o), pre_re, "R7 dropped sample");
    chk(int'(valid_o), 0, "R7 no output");
    send(-9, 4, "R7 after load");
    idle(5);
    chk(q_re.size(), 0, "R1 all outputs seen");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule